// File: doc/BRIEF.md
# Bus data trace qualifier

This block watches a system bus on behalf of a trace unit and decides which completed read and write cycles become data trace messages. A cycle is announced by an address phase (`bus_start` with address, direction, fetch flag and an initiator flag) and is later ended by one termination cycle that signals completion, abort or data error. Two trace channels each own an address window, a range-select bit and separate read and write enables. When tracing is switched on, a cycle from the DMA initiator that is not an instruction fetch and is claimed by a channel opens a pending message. That message is queued only if the cycle completes cleanly.

Tracing is switched on by a global control bit. It can also be armed by a watchpoint hit while the watchpoint's trace-start control is set. Every watchpoint hit also produces a message of its own. Both kinds of message share one circular queue whose usable depth software can limit. Entries leave the queue in arrival order over a valid/ready handshake, and a sticky flag records any message dropped because the queue was full.

A three-state cycle tracker drives the block. In `CYC_IDLE` it waits for an address phase. On `bus_start` it takes the transition *claim* to `CYC_PEND` when the cycle qualifies, or the transition *pass* to `CYC_SKIP` when it does not. From either state, any termination takes the transition *close* back to `CYC_IDLE`. A data message is pushed only on *close* out of `CYC_PEND` with a clean completion.

Top module: `trace_qual_top`

## Requirements
- R1: Tracing is on when `ctl_trace_all` is 1. It is also on when an armed latch is set. `wp_hit` sets the latch while `ctl_wp_start` is 1, and the latch clears on the clock after `ctl_wp_start` is 0. A `wp_hit` with `ctl_wp_start` set also enables a cycle that starts in the same clock. Qualification is decided when `bus_start` is sampled.
- R2: Channel c claims a read (`bus_write`=0) only if `ctl_rd_en[c]` is 1, and claims a write only if `ctl_wr_en[c]` is 1.
- R3: Channel c has window bounds lo = `ctl_win_lo[c*AW +: AW]` and hi = `ctl_win_hi[c*AW +: AW]`, both inclusive. With `ctl_outside[c]`=0 it matches when lo <= addr <= hi. With `ctl_outside[c]`=1 it matches in exactly the complementary case.
- R4: A cycle with `bus_fetch`=1 or `bus_dma`=0 never yields a data message.
- R5: A pending cycle ended by `bus_abort` yields no message. Abort takes precedence over the other termination bits.
- R6: A pending cycle ended by `bus_err` has its message discarded.
- R7: A clean completion (`bus_done` only) of a pending cycle queues one message. Its kind is 2 for a read or 3 for a write. Its channel is the lowest-numbered claiming channel, its address is taken from the address phase and its data from the completion cycle.
- R8: The head message is presented while `msg_valid`=1 and stays stable until `msg_ready`=1 at a clock edge. Messages leave in arrival order, and after reset the queue is empty.
- R9: Each `wp_hit` queues a message with kind 1, channel 0, address 0 and data 0. When it coincides with a data message, the watchpoint message is queued first.
- R10: The usable depth is `ctl_q_limit` when that value is in 1..DEPTH, and DEPTH otherwise. A message that finds the queue at this depth is dropped and sets `ovf_flag`. The flag stays set until `ctl_ovf_clear`, and a drop in the same cycle as the clear wins.
- R11: A message pushed at a clock edge is visible at the outputs right after that edge. A slot freed by a pop can be used only from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_trace_all | input | 1 | Global trace enable |
| ctl_wp_start | input | 1 | Watchpoint hit arms tracing |
| ctl_rd_en | input | NCH | Per-channel read trace enable |
| ctl_wr_en | input | NCH | Per-channel write trace enable |
| ctl_outside | input | NCH | Per-channel match outside window |
| ctl_win_lo | input | NCH*AW | Packed window start addresses |
| ctl_win_hi | input | NCH*AW | Packed window end addresses |
| ctl_q_limit | input | CW | Usable queue depth (0 = full depth) |
| ctl_ovf_clear | input | 1 | Clears the overflow flag |
| bus_start | input | 1 | Address phase strobe |
| bus_addr | input | AW | Cycle address |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_fetch | input | 1 | Instruction fetch cycle |
| bus_dma | input | 1 | Cycle started by the DMA initiator |
| bus_done | input | 1 | Clean completion strobe |
| bus_abort | input | 1 | Abort termination strobe |
| bus_err | input | 1 | Data error termination strobe |
| bus_data | input | DW | Data at completion |
| wp_hit | input | 1 | Watchpoint hit |
| msg_valid | output | 1 | Head message valid |
| msg_ready | input | 1 | Consumer takes head message |
| msg_kind | output | 2 | 1 watchpoint, 2 read, 3 write |
| msg_chan | output | CHW | Channel number |
| msg_addr | output | AW | Message address |
| msg_data | output | DW | Message data |
| ovf_flag | output | 1 | Sticky dropped-message flag |

## Verification
A watchpoint hit can land in the same clock as the clean completion of a traced cycle, so the queue must accept two entries at once. The bench asserts `wp_hit` on the termination cycle and checks that the watchpoint entry comes out before the data entry. It repeats this with a single free slot, where the watchpoint entry must be stored, the data entry dropped and the overflow flag raised. A drop coinciding with an overflow clear, and a pop coinciding with a push into a full queue, are provoked the same way and judged from the flag and the drained contents.

// File: rtl/trace_qual_pkg.sv
package trace_qual_pkg;

    typedef enum logic [1:0] {
        MSG_NONE = 2'd0,
        MSG_WP   = 2'd1,
        MSG_RD   = 2'd2,
        MSG_WR   = 2'd3
    } msg_kind_e;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_PEND = 2'd1,
        CYC_SKIP = 2'd2
    } cyc_state_e;

endpackage

// File: rtl/tq_window.sv
module tq_window #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic          outside,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic          is_write,
    output logic          claim
);
    logic in_range;
    logic dir_ok;

    always_comb begin
        in_range = (addr >= lo) && (addr <= hi);
        dir_ok   = is_write ? wr_en : rd_en;
        claim    = (in_range ^ outside) && dir_ok;
    end
endmodule

// File: rtl/tq_cycle_fsm.sv
module tq_cycle_fsm
    import trace_qual_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int NCH = 2,
    parameter int CHW = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_start,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_write,
    input  logic             bus_fetch,
    input  logic             bus_dma,
    input  logic             bus_done,
    input  logic             bus_abort,
    input  logic             bus_err,
    input  logic [DW-1:0]    bus_data,
    input  logic             trace_on,
    input  logic [NCH-1:0]   ch_claim,
    output logic             dpush,
    output logic [1:0]       dkind,
    output logic [CHW-1:0]   dchan,
    output logic [AW-1:0]    daddr,
    output logic [DW-1:0]    ddata,
    output cyc_state_e       state_o
);
    cyc_state_e     state_q;
    cyc_state_e     state_d;
    logic           qualifies;
    logic           any_term;
    logic [CHW-1:0] first_ch;
    logic           found;
    logic           pend_write;
    logic [CHW-1:0] pend_chan;
    logic [AW-1:0]  pend_addr;

    // lowest-numbered claiming channel wins
    always_comb begin
        first_ch = '0;
        found    = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (!found && ch_claim[c]) begin
                first_ch = CHW'(c);
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        qualifies = trace_on && bus_dma && !bus_fetch && found;
        any_term  = bus_done || bus_abort || bus_err;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CYC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CYC_IDLE: begin
                if (bus_start) begin
                    state_d = qualifies ? CYC_PEND : CYC_SKIP;
                end
            end
            CYC_PEND: begin
                if (any_term) begin
                    state_d = CYC_IDLE;
                end
            end
            CYC_SKIP: begin
                if (any_term) begin
                    state_d = CYC_IDLE;
                end
            end
            default: state_d = CYC_IDLE;
        endcase
    end

    // pending message fields captured at claim
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_write <= 1'b0;
            pend_chan  <= '0;
            pend_addr  <= '0;
        end else if (state_q == CYC_IDLE && bus_start) begin
            pend_write <= bus_write;
            pend_chan  <= first_ch;
            pend_addr  <= bus_addr;
        end
    end

    // outputs
    always_comb begin
        dpush   = 1'b0;
        dkind   = pend_write ? MSG_WR : MSG_RD;
        dchan   = pend_chan;
        daddr   = pend_addr;
        ddata   = bus_data;
        state_o = state_q;
        unique case (state_q)
            CYC_PEND: dpush = bus_done && !bus_abort && !bus_err;
            CYC_IDLE: dpush = 1'b0;
            CYC_SKIP: dpush = 1'b0;
            default:  dpush = 1'b0;
        endcase
    end
endmodule

// File: rtl/tq_msg_queue.sv
module tq_msg_queue #(
    parameter int MW    = 8,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_a,
    input  logic [MW-1:0] din_a,
    input  logic          push_b,
    input  logic [MW-1:0] din_b,
    input  logic          pop_ready,
    input  logic [CW-1:0] limit,
    input  logic          ovf_clear,
    output logic          out_valid,
    output logic [MW-1:0] dout,
    output logic          ovf,
    output logic [CW-1:0] count_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [MW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic [CW-1:0] eff;
    logic          acc_a;
    logic          acc_b;
    logic          pop;
    logic          drop;
    logic [PW-1:0] slot_b;
    logic [PW-1:0] wr_next;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        eff       = (limit == '0 || limit > DEPTH_C) ? DEPTH_C : limit;
        acc_a     = push_a && (count < eff);
        acc_b     = push_b && (({1'b0, count} + {{CW{1'b0}}, acc_a}) < {1'b0, eff});
        drop      = (push_a && !acc_a) || (push_b && !acc_b);
        out_valid = (count != '0);
        pop       = out_valid && pop_ready;
        slot_b    = acc_a ? step(wr_ptr) : wr_ptr;
        wr_next   = acc_b ? step(slot_b) : (acc_a ? step(wr_ptr) : wr_ptr);
        dout      = mem[rd_ptr];
        count_o   = count;
    end

    always_ff @(posedge clk) begin
        if (acc_a) begin
            mem[wr_ptr] <= din_a;
        end
        if (acc_b) begin
            mem[slot_b] <= din_b;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            wr_ptr <= wr_next;
            if (pop) begin
                rd_ptr <= step(rd_ptr);
            end
            count <= count + CW'(acc_a) + CW'(acc_b) - CW'(pop);
            if (drop) begin
                ovf <= 1'b1;
            end else if (ovf_clear) begin
                ovf <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/trace_qual_top.sv
module trace_qual_top
    import trace_qual_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int NCH   = 2,
    parameter int DEPTH = 8,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int MW   = 2 + CHW + AW + DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_trace_all,
    input  logic               ctl_wp_start,
    input  logic [NCH-1:0]     ctl_rd_en,
    input  logic [NCH-1:0]     ctl_wr_en,
    input  logic [NCH-1:0]     ctl_outside,
    input  logic [NCH*AW-1:0]  ctl_win_lo,
    input  logic [NCH*AW-1:0]  ctl_win_hi,
    input  logic [CW-1:0]      ctl_q_limit,
    input  logic               ctl_ovf_clear,
    input  logic               bus_start,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_write,
    input  logic               bus_fetch,
    input  logic               bus_dma,
    input  logic               bus_done,
    input  logic               bus_abort,
    input  logic               bus_err,
    input  logic [DW-1:0]      bus_data,
    input  logic               wp_hit,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [1:0]         msg_kind,
    output logic [CHW-1:0]     msg_chan,
    output logic [AW-1:0]      msg_addr,
    output logic [DW-1:0]      msg_data,
    output logic               ovf_flag
);
    logic            armed;
    logic            trace_on;
    logic [NCH-1:0]  ch_claim;
    logic            data_push;
    logic [1:0]      d_kind;
    logic [CHW-1:0]  d_chan;
    logic [AW-1:0]   d_addr;
    logic [DW-1:0]   d_data;
    cyc_state_e      fsm_state;
    logic [MW-1:0]   wp_word;
    logic [MW-1:0]   data_word;
    logic [MW-1:0]   head_word;
    logic [CW-1:0]   q_count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= ctl_wp_start && (armed || wp_hit);
        end
    end

    always_comb begin
        trace_on = ctl_trace_all || armed || (wp_hit && ctl_wp_start);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_win
        tq_window #(.AW(AW)) u_win (
            .addr     (bus_addr),
            .lo       (ctl_win_lo[c*AW +: AW]),
            .hi       (ctl_win_hi[c*AW +: AW]),
            .outside  (ctl_outside[c]),
            .rd_en    (ctl_rd_en[c]),
            .wr_en    (ctl_wr_en[c]),
            .is_write (bus_write),
            .claim    (ch_claim[c])
        );
    end

    tq_cycle_fsm #(.AW(AW), .DW(DW), .NCH(NCH), .CHW(CHW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_addr  (bus_addr),
        .bus_write (bus_write),
        .bus_fetch (bus_fetch),
        .bus_dma   (bus_dma),
        .bus_done  (bus_done),
        .bus_abort (bus_abort),
        .bus_err   (bus_err),
        .bus_data  (bus_data),
        .trace_on  (trace_on),
        .ch_claim  (ch_claim),
        .dpush     (data_push),
        .dkind     (d_kind),
        .dchan     (d_chan),
        .daddr     (d_addr),
        .ddata     (d_data),
        .state_o   (fsm_state)
    );

    always_comb begin
        wp_word   = {MSG_WP, {CHW{1'b0}}, {AW{1'b0}}, {DW{1'b0}}};
        data_word = {d_kind, d_chan, d_addr, d_data};
    end

    // port a (watchpoint) is placed ahead of port b (data)
    tq_msg_queue #(.MW(MW), .DEPTH(DEPTH), .CW(CW)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_a    (wp_hit),
        .din_a     (wp_word),
        .push_b    (data_push),
        .din_b     (data_word),
        .pop_ready (msg_ready),
        .limit     (ctl_q_limit),
        .ovf_clear (ctl_ovf_clear),
        .out_valid (msg_valid),
        .dout      (head_word),
        .ovf       (ovf_flag),
        .count_o   (q_count)
    );

    always_comb begin
        msg_kind = head_word[MW-1 -: 2];
        msg_chan = head_word[AW+DW +: CHW];
        msg_addr = head_word[DW +: AW];
        msg_data = head_word[DW-1:0];
    end
endmodule

// File: rtl/tq_checker.sv
module tq_checker
    import trace_qual_pkg::*;
#(
    parameter int MW    = 8,
    parameter int CW    = 4,
    parameter int DEPTH = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          msg_valid,
    input logic          msg_ready,
    input logic [MW-1:0] head_word,
    input logic          ovf_flag,
    input logic          ovf_clear,
    input logic          bus_start,
    input logic          bus_fetch,
    input logic          bus_abort,
    input logic          bus_err,
    input logic          dpush,
    input cyc_state_e    state,
    input logic [CW-1:0] q_count,
    input logic          wp_hit
);
    a_r8_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(head_word)));

    a_r10_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clear) |=> ovf_flag);

    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count <= CW'(DEPTH)));

    a_r5_no_push_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
        bus_abort |-> !dpush);

    a_r6_no_push_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> !dpush);

    a_r4_fetch_skipped: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CYC_IDLE && bus_start && bus_fetch) |=> (state == CYC_SKIP));

    a_r9_wp_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_hit && q_count == '0) |=> msg_valid);
endmodule

bind trace_qual_top tq_checker #(.MW(MW), .CW(CW), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .head_word (head_word),
    .ovf_flag  (ovf_flag),
    .ovf_clear (ctl_ovf_clear),
    .bus_start (bus_start),
    .bus_fetch (bus_fetch),
    .bus_abort (bus_abort),
    .bus_err   (bus_err),
    .dpush     (data_push),
    .state     (fsm_state),
    .q_count   (q_count),
    .wp_hit    (wp_hit)
);

// File: tb/sim_trace_qual_top.sv
module sim_trace_qual_top;
    localparam int CLK_P = 10;
    localparam int AW    = 8;
    localparam int DW    = 8;
    localparam int NCH   = 2;
    localparam int DEPTH = 4;
    localparam int CW    = 3;
    localparam logic [7:0] ADDRS [8] = '{8'h1F, 8'h20, 8'h2F, 8'h30, 8'h3F, 8'h40, 8'h7F, 8'h80};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_trace_all = 1'b0, ctl_wp_start = 1'b0, ctl_ovf_clear = 1'b0;
    logic [1:0] ctl_rd_en = '0, ctl_wr_en = '0, ctl_outside = '0;
    logic [15:0] ctl_win_lo = {8'h30, 8'h20};
    logic [15:0] ctl_win_hi = {8'h7F, 8'h3F};
    logic [CW-1:0] ctl_q_limit = '0;
    logic bus_start = 0, bus_write = 0, bus_fetch = 0, bus_dma = 0;
    logic bus_done = 0, bus_abort = 0, bus_err = 0, wp_hit = 0, msg_ready = 0;
    logic [7:0] bus_addr = '0, bus_data = '0;
    logic msg_valid, ovf_flag;
    logic [1:0] msg_kind;
    logic msg_chan;
    logic [7:0] msg_addr, msg_data;

    int nchk = 0;
    int nfail = 0;
    bit done_flag = 0;

    always #(CLK_P/2) clk = ~clk;

    trace_qual_top #(.AW(AW), .DW(DW), .NCH(NCH), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_trace_all(ctl_trace_all), .ctl_wp_start(ctl_wp_start),
        .ctl_rd_en(ctl_rd_en), .ctl_wr_en(ctl_wr_en), .ctl_outside(ctl_outside),
        .ctl_win_lo(ctl_win_lo), .ctl_win_hi(ctl_win_hi), .ctl_q_limit(ctl_q_limit),
        .ctl_ovf_clear(ctl_ovf_clear), .bus_start(bus_start), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_fetch(bus_fetch), .bus_dma(bus_dma), .bus_done(bus_done),
        .bus_abort(bus_abort), .bus_err(bus_err), .bus_data(bus_data), .wp_hit(wp_hit),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind), .msg_chan(msg_chan),
        .msg_addr(msg_addr), .msg_data(msg_data), .ovf_flag(ovf_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    // one bus cycle: address phase, then termination (0 done, 1 abort, 2 error)
    task automatic bus_cycle(input logic [7:0] a, input bit w, input bit f, input bit dma,
                             input int term, input logic [7:0] d, input bit wp);
        @(negedge clk);
        bus_start = 1; bus_addr = a; bus_write = w; bus_fetch = f; bus_dma = dma;
        @(negedge clk);
        bus_start = 0;
        bus_done = (term == 0); bus_abort = (term == 1); bus_err = (term == 2);
        bus_data = d; wp_hit = wp;
        @(negedge clk);
        bus_done = 0; bus_abort = 0; bus_err = 0; wp_hit = 0;
    endtask

    task automatic wp_pulse();
        @(negedge clk);
        wp_hit = 1;
        @(negedge clk);
        wp_hit = 0;
    endtask

    // called at a negedge: compare head, then pop it
    task automatic expect_msg(input logic [1:0] k, input logic c, input logic [7:0] a,
                              input logic [7:0] d, input string req);
        logic [19:0] act, exp;
        act = {msg_valid, msg_kind, msg_chan, msg_addr, msg_data};
        exp = {1'b1, k, c, a, d};
        chk(act == exp, req, 32'(act), 32'(exp));
        msg_ready = 1;
        @(negedge clk);
        msg_ready = 0;
    endtask

    task automatic expect_none(input string req);
        chk(msg_valid == 1'b0, req, 32'(msg_valid), 32'd0);
    endtask

    function automatic int exp_chan(input logic [7:0] a, input bit w, input int o, input int en);
        for (int c = 0; c < 2; c++) begin
            int lo = (c == 1) ? 8'h30 : 8'h20;
            int hi = (c == 1) ? 8'h7F : 8'h3F;
            bit inw = (int'(a) >= lo) && (int'(a) <= hi);
            bit outb = ((o >> c) & 1) != 0;
            bit enb = w ? (((en >> (2 + c)) & 1) != 0) : (((en >> c) & 1) != 0);
            if ((inw != outb) && enb) return c;
        end
        return -1;
    endfunction

    initial begin
        #(CLK_P * 150000);
        if (!done_flag) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8 / R10: reset state
        chk(msg_valid == 0, "R8 reset empty", 32'(msg_valid), 0);
        chk(ovf_flag == 0, "R10 reset ovf", 32'(ovf_flag), 0);

        // R2/R3/R7 sweep over range bits, enables, direction and window edges
        ctl_trace_all = 1;
        for (int o = 0; o < 4; o++) begin
            for (int en = 0; en < 16; en++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int ai = 0; ai < 8; ai++) begin
                        int ec;
                        logic [7:0] a;
                        a = ADDRS[ai];
                        ctl_outside = 2'(o);
                        ctl_rd_en = en[1:0];
                        ctl_wr_en = en[3:2];
                        bus_cycle(a, w[0], 0, 1, 0, a ^ 8'h5A, 0);
                        ec = exp_chan(a, w[0], o, en);
                        if (ec < 0) expect_none("R2/R3 sweep no claim");
                        else expect_msg(w[0] ? 2'd3 : 2'd2, ec[0], a, a ^ 8'h5A, "R2/R3/R7 sweep");
                    end
                end
            end
        end

        ctl_outside = 0; ctl_rd_en = 2'b11; ctl_wr_en = 2'b11;

        // R1: everything off
        ctl_trace_all = 0;
        bus_cycle(8'h25, 0, 0, 1, 0, 8'h11, 0);
        expect_none("R1 trace off");

        // R9 / R1: hit without start control gives a message but no arming
        wp_pulse();
        expect_msg(2'd1, 0, 8'h00, 8'h00, "R9 wp message");
        bus_cycle(8'h25, 0, 0, 1, 0, 8'h12, 0);
        expect_none("R1 not armed");

        // R1: armed by hit with start control
        ctl_wp_start = 1;
        wp_pulse();
        expect_msg(2'd1, 0, 8'h00, 8'h00, "R9 wp message armed");
        bus_cycle(8'h26, 0, 0, 1, 0, 8'h13, 0);
        expect_msg(2'd2, 0, 8'h26, 8'h13, "R1 armed trace");
        ctl_wp_start = 0;
        @(negedge clk);
        bus_cycle(8'h26, 0, 0, 1, 0, 8'h14, 0);
        expect_none("R1 disarmed");

        // R4, R5, R6
        ctl_trace_all = 1;
        bus_cycle(8'h27, 0, 1, 1, 0, 8'h15, 0);
        expect_none("R4 fetch");
        bus_cycle(8'h27, 1, 0, 0, 0, 8'h16, 0);
        expect_none("R4 non-dma");
        bus_cycle(8'h27, 1, 0, 1, 1, 8'h17, 0);
        expect_none("R5 abort");
        bus_cycle(8'h27, 0, 0, 1, 2, 8'h18, 0);
        expect_none("R6 error");

        // R11: visibility right after the termination edge
        @(negedge clk);
        bus_start = 1; bus_addr = 8'h28; bus_write = 1; bus_fetch = 0; bus_dma = 1;
        @(negedge clk);
        bus_start = 0; bus_done = 1; bus_data = 8'h19;
        chk(msg_valid == 0, "R11 not before edge", 32'(msg_valid), 0);
        @(negedge clk);
        bus_done = 0;
        expect_msg(2'd3, 0, 8'h28, 8'h19, "R11 visible after edge");

        // R9: simultaneous watchpoint and data message
        bus_cycle(8'h29, 1, 0, 1, 0, 8'h1A, 1);
        expect_msg(2'd1, 0, 8'h00, 8'h00, "R9 wp first");
        expect_msg(2'd3, 0, 8'h29, 8'h1A, "R9 data second");
        expect_none("R9 pair only");

        // R8: arrival order
        bus_cycle(8'h21, 0, 0, 1, 0, 8'hA1, 0);
        bus_cycle(8'h32, 1, 0, 1, 0, 8'hA2, 0);
        bus_cycle(8'h50, 0, 0, 1, 0, 8'hA3, 0);
        expect_msg(2'd2, 0, 8'h21, 8'hA1, "R8 order 1");
        expect_msg(2'd3, 0, 8'h32, 8'hA2, "R8 order 2");
        expect_msg(2'd2, 1, 8'h50, 8'hA3, "R8 order 3");

        // R10: limit of two
        ctl_q_limit = 3'd2;
        bus_cycle(8'h24, 0, 0, 1, 0, 8'hB1, 0);
        bus_cycle(8'h25, 0, 0, 1, 0, 8'hB2, 0);
        bus_cycle(8'h26, 0, 0, 1, 0, 8'hB3, 0);
        chk(ovf_flag == 1, "R10 overflow set", 32'(ovf_flag), 1);
        expect_msg(2'd2, 0, 8'h24, 8'hB1, "R10 kept 1");
        expect_msg(2'd2, 0, 8'h25, 8'hB2, "R10 kept 2");
        expect_none("R10 third dropped");
        chk(ovf_flag == 1, "R10 overflow sticky", 32'(ovf_flag), 1);
        ctl_ovf_clear = 1;
        @(negedge clk);
        ctl_ovf_clear = 0;
        chk(ovf_flag == 0, "R10 overflow cleared", 32'(ovf_flag), 0);

        // R9/R10: one free slot, simultaneous pushes
        bus_cycle(8'h2A, 1, 0, 1, 0, 8'hC1, 0);
        bus_cycle(8'h2B, 1, 0, 1, 0, 8'hC2, 1);
        chk(ovf_flag == 1, "R10 pair overflow", 32'(ovf_flag), 1);
        expect_msg(2'd3, 0, 8'h2A, 8'hC1, "R10 earlier kept");
        expect_msg(2'd1, 0, 8'h00, 8'h00, "R9 wp takes last slot");
        expect_none("R9 data dropped");
        ctl_ovf_clear = 1;
        @(negedge clk);
        ctl_ovf_clear = 0;

        // R10: drop beats clear
        ctl_q_limit = 3'd1;
        wp_pulse();
        @(negedge clk);
        wp_hit = 1; ctl_ovf_clear = 1;
        @(negedge clk);
        wp_hit = 0; ctl_ovf_clear = 0;
        chk(ovf_flag == 1, "R10 drop wins over clear", 32'(ovf_flag), 1);

        // R11: pop and push in the same cycle on a full queue
        msg_ready = 1; wp_hit = 1;
        @(negedge clk);
        msg_ready = 0; wp_hit = 0;
        expect_none("R11 freed slot not reused same edge");
        ctl_ovf_clear = 1;
        @(negedge clk);
        ctl_ovf_clear = 0;

        // R10: out-of-range limit means full depth
        ctl_q_limit = 3'd7;
        for (int i = 0; i < 5; i++) wp_pulse();
        chk(ovf_flag == 1, "R10 full depth overflow", 32'(ovf_flag), 1);
        for (int i = 0; i < DEPTH; i++) expect_msg(2'd1, 0, 8'h00, 8'h00, "R10 full depth entry");
        expect_none("R10 full depth drained");

        done_flag = 1;
        report();
    end
endmodule